// File: doc/BRIEF.md
# Managed Ethernet PHY Register Model

This block stands in for one Ethernet transceiver's 32-entry management register file. A management master issues read or write requests over a parallel request port, each carrying a 5-bit device address, a 5-bit register index and a 16-bit write word. The block answers each request with a single-cycle response pulse that carries the read word. The bit-serial management framing is not modelled. A bridge or a verification environment can sit directly on the parallel port.

Most registers are plain storage that returns the last value written. Four indices never return their stored value. The status, partner-ability and diagnostic registers are built on every read from the current link input and the advertisement register. One vendor-specific index returns a fixed speed indication. The software-reset bit of the control register clears itself after every write. A request aimed at any device address other than the configured one sees a bus with nobody on it: reads float to all ones and writes are dropped.

Back-pressure rules: `req_ready` is low while reset is asserted and during the first clock after release. After that it stays high, so a request is taken in any cycle in which `req_valid` is high. The response side has no ready input. The consumer must take `rsp_valid` in the cycle it appears, one clock after acceptance. Back-to-back requests produce back-to-back responses.

Top module: `mdio_phy_regmodel`

## Requirements
- R1: After reset, index 0 reads 0x3100, index 2 reads 0x0300, index 3 reads 0xE400, index 4 reads 0x01E1, and every other storage index reads 0x0000.
- R2: Index 1 reads 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1) while `link_up` is 1, and reads 0x0000 while `link_up` is 0, whatever was written to it.
- R3: Index 5 reads 0x4000 OR (index 4 AND 0x01E0) OR 0x0001.
- R4: Index 17 always reads 0x8000, independent of link state and of writes.
- R5: While `link_up` is 1, index 18 reads bit 10 set when index 4 has 0x0080 or 0x0100 set, and bit 11 set when index 4 has 0x0100 or 0x0040 set, with all other bits zero. While `link_up` is 0 it reads 0x0000.
- R6: A write to the configured device stores the 16-bit word at the addressed index. Later reads of that index return it, except at indices 1, 5, 17 and 18, which always read their computed values.
- R7: After any accepted write to the configured device, bit 15 of index 0 is 0. A word written to index 0 is stored with bit 15 cleared.
- R8: A read whose device address differs from parameter `PHY_ADDR` (default 7) returns 0xFFFF. A write to such an address changes no register.
- R9: Each request accepted on a rising edge (`req_valid` and `req_ready` both high) produces `rsp_valid` high for exactly the next cycle. No response appears without a request. A write's response carries 0x0000.
- R10: The link state used for computed registers is the value of `link_up` in the cycle the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Current link indication feeding the computed registers |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target device address |
| req_reg | input | 5 | Register index |
| req_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 16 | Read word (0x0000 for writes) |

## Verification
The bench sweeps the advertisement register through each single-mode value and an all-ones value. A model that confused the half-duplex and full-duplex masks, or copied the wrong field into index 5, would return the wrong speed or duplex bits there. It writes index 0 with bit 15 set and reads it back, which catches a reset bit that sticks. It writes the computed indices and reads them back to show that the stored word does not leak through. It toggles the link between requests to show that the status reads follow the link at acceptance time. It also sends a write to a foreign address and then reads the own advertisement register, which exposes a decoder that ignores the device address. Back-to-back requests check that responses are neither merged nor lost.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int RA_W = 5;
  localparam int DW   = 16;
  localparam int NREG = 1 << RA_W;

  typedef logic [RA_W-1:0] reg_idx_t;
  typedef logic [DW-1:0]   word_t;

  // Register indices whose behaviour differs from plain storage.
  localparam reg_idx_t IDX_CTRL    = 5'd0;
  localparam reg_idx_t IDX_STAT    = 5'd1;
  localparam reg_idx_t IDX_ID_HI   = 5'd2;
  localparam reg_idx_t IDX_ID_LO   = 5'd3;
  localparam reg_idx_t IDX_ADV     = 5'd4;
  localparam reg_idx_t IDX_PARTNER = 5'd5;
  localparam reg_idx_t IDX_VSPEC   = 5'd17;
  localparam reg_idx_t IDX_DIAG    = 5'd18;

  localparam word_t CTRL_SWRST   = 16'h8000;
  localparam word_t ADV_10_HALF  = 16'h0020;
  localparam word_t ADV_10_FULL  = 16'h0040;
  localparam word_t ADV_100_HALF = 16'h0080;
  localparam word_t ADV_100_FULL = 16'h0100;
  localparam word_t ADV_MODES    = ADV_10_HALF | ADV_10_FULL | ADV_100_HALF | ADV_100_FULL;
  localparam word_t STAT_UP      = 16'h782E;
  localparam word_t PARTNER_BASE = 16'h4001;
  localparam word_t VSPEC_VALUE  = 16'h8000;
  localparam word_t DIAG_SPD100  = 16'h0400;
  localparam word_t DIAG_FULLDPX = 16'h0800;
  localparam word_t BUS_FLOAT    = 16'hFFFF;

  function automatic word_t init_value(input int unsigned idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
  import phy_mgmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  reg_idx_t wr_idx,
  input  word_t    wr_data,
  input  reg_idx_t rd_idx,
  output word_t    rd_data,
  output word_t    adv_q
);
  word_t cells [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    localparam word_t RST_VAL = init_value(i);
    word_t q;
    if (i == 0) begin : g_ctrl
      // Control register: software-reset bit drops after every write.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else if (wr_en) q <= ((wr_idx == reg_idx_t'(i)) ? wr_data : q) & ~CTRL_SWRST;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else if (wr_en && wr_idx == reg_idx_t'(i)) q <= wr_data;
      end
    end
    assign cells[i] = q;
  end

  assign rd_data = cells[rd_idx];
  assign adv_q   = cells[IDX_ADV];

  p_ctrl_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !cells[0][15]);
endmodule

// File: rtl/phy_live_status.sv
module phy_live_status
  import phy_mgmt_pkg::*;
(
  input  logic     link,
  input  word_t    adv,
  input  reg_idx_t idx,
  output logic     live_hit,
  output word_t    live_data
);
  logic spd100, fulldpx;

  always_comb begin
    spd100  = |(adv & (ADV_100_HALF | ADV_100_FULL));
    fulldpx = |(adv & (ADV_100_FULL | ADV_10_FULL));
    live_hit  = 1'b1;
    live_data = '0;
    case (idx)
      IDX_STAT:    live_data = link ? STAT_UP : '0;
      IDX_PARTNER: live_data = PARTNER_BASE | (adv & ADV_MODES);
      IDX_VSPEC:   live_data = VSPEC_VALUE;
      IDX_DIAG:    live_data = link ? ((spd100 ? DIAG_SPD100 : '0) |
                                       (fulldpx ? DIAG_FULLDPX : '0)) : '0;
      default:     live_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (live_hit && idx == IDX_VSPEC)
      a_vspec_fixed_r4: assert (live_data == VSPEC_VALUE);
  end
endmodule

// File: rtl/phy_rsp_stage.sv
module phy_rsp_stage
  import phy_mgmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  word_t data_in,
  output logic  rsp_valid,
  output word_t rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_data <= data_in;
    end
  end

  p_ack_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  p_no_spurious_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);
endmodule

// File: rtl/mdio_phy_regmodel.sv
module mdio_phy_regmodel
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata
);
  localparam logic [RA_W-1:0] OWN_ADDR = PHY_ADDR[RA_W-1:0];

  logic  ready_q, fire, own, wr_en, live_hit;
  word_t store_rd, adv_q, live_data, rsp_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign fire      = req_valid && ready_q;
  assign own       = (req_phy == OWN_ADDR);
  assign wr_en     = fire && req_write && own;

  phy_reg_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(req_reg),
    .wr_data(req_wdata), .rd_idx(req_reg), .rd_data(store_rd), .adv_q(adv_q)
  );

  phy_live_status u_live (
    .link(link_up), .adv(adv_q), .idx(req_reg),
    .live_hit(live_hit), .live_data(live_data)
  );

  always_comb begin
    if (req_write)     rsp_in = '0;
    else if (!own)     rsp_in = BUS_FLOAT;
    else if (live_hit) rsp_in = live_data;
    else               rsp_in = store_rd;
  end

  phy_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .data_in(rsp_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
  );

  p_foreign_read_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && !own) |=> (rsp_rdata == 16'hFFFF));
  p_foreign_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && !own) |=> $stable(adv_q));
  p_stat_link_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && own && req_reg == IDX_STAT && !link_up) |=> (rsp_rdata == 16'h0000));
  p_vspec_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && own && req_reg == IDX_VSPEC) |=> (rsp_rdata == 16'h8000));
endmodule

// File: tb/mdio_phy_regmodel_tb_top.sv
module mdio_phy_regmodel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] OWN = 5'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_phy_regmodel #(.PHY_ADDR(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One transaction: drive at negedge, sample response at following negedge.
  task automatic xact(input logic wr, input logic [4:0] phy, input logic [4:0] idx,
                      input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = idx; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL R9: rsp_valid got %b expected 1", rsp_valid);
    end
    rd = rsp_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] phy, input logic [4:0] idx,
                        input logic [15:0] exp);
    logic [15:0] d;
    xact(1'b0, phy, idx, 16'h0, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(input logic [4:0] idx, input logic [15:0] wd);
    logic [15:0] d;
    xact(1'b1, OWN, idx, wd, d);
    chk("R9 write data", d, 16'h0000);
  endtask

  task automatic t_reset;
    chk("R9 ready after reset", {15'b0, req_ready}, 16'h0001);
    chk("R9 idle rsp_valid", {15'b0, rsp_valid}, 16'h0000);
    rd_chk("R1 idx0", OWN, 5'd0, 16'h3100);
    rd_chk("R1 idx2", OWN, 5'd2, 16'h0300);
    rd_chk("R1 idx3", OWN, 5'd3, 16'hE400);
    rd_chk("R1 idx4", OWN, 5'd4, 16'h01E1);
    rd_chk("R1 idx9", OWN, 5'd9, 16'h0000);
    rd_chk("R1 idx31", OWN, 5'd31, 16'h0000);
  endtask

  task automatic t_link;
    link_up = 1'b1;
    rd_chk("R2 stat up", OWN, 5'd1, 16'h782E);
    rd_chk("R5 diag default", OWN, 5'd18, 16'h0C00);
    rd_chk("R3 partner default", OWN, 5'd5, 16'h41E1);
    rd_chk("R4 vspec up", OWN, 5'd17, 16'h8000);
    link_up = 1'b0;
    rd_chk("R2 R10 stat down", OWN, 5'd1, 16'h0000);
    rd_chk("R5 R10 diag down", OWN, 5'd18, 16'h0000);
    rd_chk("R4 vspec down", OWN, 5'd17, 16'h8000);
    link_up = 1'b1;
    rd_chk("R10 stat back up", OWN, 5'd1, 16'h782E);
  endtask

  task automatic t_adv;
    wr(5'd4, 16'h0020);
    rd_chk("R3 partner 10h", OWN, 5'd5, 16'h4021);
    rd_chk("R5 diag 10h", OWN, 5'd18, 16'h0000);
    wr(5'd4, 16'h0040);
    rd_chk("R3 partner 10f", OWN, 5'd5, 16'h4041);
    rd_chk("R5 diag 10f", OWN, 5'd18, 16'h0800);
    wr(5'd4, 16'h0080);
    rd_chk("R3 partner 100h", OWN, 5'd5, 16'h4081);
    rd_chk("R5 diag 100h", OWN, 5'd18, 16'h0400);
    wr(5'd4, 16'h0100);
    rd_chk("R3 partner 100f", OWN, 5'd5, 16'h4101);
    rd_chk("R5 diag 100f", OWN, 5'd18, 16'h0C00);
    wr(5'd4, 16'hFFFF);
    rd_chk("R6 adv readback", OWN, 5'd4, 16'hFFFF);
    rd_chk("R3 partner ones", OWN, 5'd5, 16'h41E1);
    wr(5'd4, 16'h01E1);
  endtask

  task automatic t_storage;
    wr(5'd9, 16'hA5A5);
    wr(5'd31, 16'h1234);
    rd_chk("R6 idx9", OWN, 5'd9, 16'hA5A5);
    rd_chk("R6 idx31", OWN, 5'd31, 16'h1234);
    wr(5'd1, 16'h0000);
    wr(5'd5, 16'h0000);
    wr(5'd17, 16'h1111);
    wr(5'd18, 16'hFFFF);
    rd_chk("R6 R2 stat not stored", OWN, 5'd1, 16'h782E);
    rd_chk("R6 R3 partner not stored", OWN, 5'd5, 16'h41E1);
    rd_chk("R6 R4 vspec not stored", OWN, 5'd17, 16'h8000);
    rd_chk("R6 R5 diag not stored", OWN, 5'd18, 16'h0C00);
  endtask

  task automatic t_selfclear;
    wr(5'd0, 16'h9200);
    rd_chk("R7 ctrl bit15 cleared", OWN, 5'd0, 16'h1200);
    wr(5'd0, 16'hFFFF);
    rd_chk("R7 ctrl all ones", OWN, 5'd0, 16'h7FFF);
    wr(5'd12, 16'h0001);
    rd_chk("R7 ctrl after other write", OWN, 5'd0, 16'h7FFF);
  endtask

  task automatic t_foreign;
    logic [15:0] d;
    rd_chk("R8 foreign idx4", 5'd3, 5'd4, 16'hFFFF);
    rd_chk("R8 foreign idx17", 5'd8, 5'd17, 16'hFFFF);
    xact(1'b1, 5'd6, 5'd4, 16'h0000, d);
    xact(1'b1, 5'd31, 5'd9, 16'h0000, d);
    rd_chk("R8 own adv untouched", OWN, 5'd4, 16'h01E1);
    rd_chk("R8 own idx9 untouched", OWN, 5'd9, 16'hA5A5);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_phy = OWN; req_reg = 5'd2;
    @(negedge clk);
    chk("R9 b2b first valid", {15'b0, rsp_valid}, 16'h0001);
    chk("R9 b2b first data", rsp_rdata, 16'h0300);
    req_reg = 5'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 b2b second valid", {15'b0, rsp_valid}, 16'h0001);
    chk("R9 b2b second data", rsp_rdata, 16'hE400);
    @(negedge clk);
    chk("R9 pulse ends", {15'b0, rsp_valid}, 16'h0000);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ready low in reset", {15'b0, req_ready}, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_link();
    t_adv();
    t_storage();
    t_selfclear();
    t_foreign();
    t_b2b();
    summary();
  end
endmodule